// File: doc/BRIEF.md
# Dual-Reference Phase Comparison Monitor

This block turns the phase detector of a secondary timing loop into a measuring instrument. A primary detector always compares the reference that the primary loop has selected with that loop's feedback edge. The secondary detector has two uses. In normal operation it compares a software-forced reference with the secondary loop's feedback. In measure mode the secondary loop is told to stop locking and run free. Its detector then compares a copy of the primary loop's selected reference with the forced reference, so software can rotate the force index across all inputs and watch the wander of each input against the active one.

Each reference arrives as a one-cycle clock-enable pulse on `ref_pulse`. When the divide configuration bit is set, both edges entering the secondary detector are divided by the same ratio, so the primary copy always runs at the secondary path's compare rate. Each detector stamps edges with a free-running 9-bit cycle counter and forms a signed 9-bit difference. The result is smoothed by a first-order IIR. A select bit routes either smoothed value to a two-byte register read port, and reading the low byte freezes the high byte for the read that follows. Reads are plain strobes with no back-pressure. A read always completes one cycle after its strobe.

Top module: `phase_cmp_monitor`

## Requirements
- R1: After reset both smoothed phases read as 0x0000 and `sec_lock_en` is 1.
- R2: `sec_lock_en` is 0 in the cycle after any cycle with `meas_mode` high, and 1 in the cycle after any cycle with it low.
- R3: In measure mode a secondary sample equals (cycle of the forced reference edge) minus (cycle of the primary-selected reference edge), wrapped into the signed 9-bit range -256..255. A sample is formed once both edges have been seen, and the latest edge of each kind is the one used.
- R4: `force_sel` may name any input, including the one `pri_sel` names. Forcing the primary's own reference gives samples of 0.
- R5: With `div_mode` = 1 both secondary inputs pass only every DIV-th pulse, counted from reset over the pulses seen while `div_mode` is 1 (DIV = 4 by default).
- R6: With `div_mode` = 0 every pulse reaches the secondary detector undivided.
- R7: Outside measure mode the secondary sample is (`sec_fb_pulse` cycle) minus (forced reference cycle). In measure mode `sec_fb_pulse` has no effect.
- R8: The primary sample is (`pri_fb_pulse` cycle) minus (`ref_pulse[pri_sel]` cycle), taken undivided, whatever the value of `meas_mode`.
- R9: Each detector's smoothed value is updated once per sample by the rule acc += ((x << K) - acc) >>> K. The readable phase is acc >>> K, with K = 3 by default.
- R10: `rd_sec` = 0 selects the primary smoothed phase and 1 selects the secondary.
- R11: The read word is the selected 9-bit phase sign-extended to 16 bits. `rd_en` with `rd_addr` = 0 returns bits 7:0 on `rd_data` in the next cycle. Without `rd_en`, `rd_data` holds.
- R12: A read with `rd_addr` = 1 returns bits 15:8 of the word as it stood at the last `rd_addr` = 0 read, even if the phase has changed since then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | N_REF | One-cycle edge pulse per reference input |
| pri_sel | input | IDX_W | Index of the primary loop's selected reference |
| force_sel | input | IDX_W | Forced secondary reference index |
| pri_fb_pulse | input | 1 | Primary loop feedback edge pulse |
| sec_fb_pulse | input | 1 | Secondary loop feedback edge pulse |
| meas_mode | input | 1 | 1 = secondary detector measures between two references |
| div_mode | input | 1 | 1 = divide secondary detector inputs by DIV |
| rd_sec | input | 1 | Readout source: 0 primary, 1 secondary |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 1 | 0 = low byte (takes snapshot), 1 = high byte |
| rd_data | output | 8 | Read data, valid the cycle after the strobe |
| sec_lock_en | output | 1 | Secondary loop may lock (low while measuring) |

## Verification
The hardest case to reach from the ports is a read whose two bytes straddle a change of the smoothed value's sign. The snapshot only matters if the high byte differs between read time and snapshot time. The stimulus first settles the secondary phase at a large positive offset and reads the low byte. It then drives many edge groups at a large negative offset before reading the high byte. Divided mode is reached by driving exactly one edge group per pulse, so the bench's own divide counter stays aligned with the design's. Constrained random offsets are then mixed with directed groups where both references coincide.

// File: rtl/phase_cmp_pkg.sv
package phase_cmp_pkg;
  localparam int PHASE_W = 9;
  localparam int WORD_W  = 16;
  typedef logic signed [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/pcm_edge_div.sv
module pcm_edge_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pulse_i,
  output logic pulse_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (en && pulse_i) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign pulse_o = pulse_i && (!en || cnt == LAST);
endmodule

// File: rtl/pcm_phase_det.sv
module pcm_phase_det
  import phase_cmp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   a_i,
  input  logic   b_i,
  output logic   vld_o,
  output phase_t phase_o
);
  logic [PHASE_W-1:0] tick, a_ts, b_ts, a_t, b_t;
  logic a_seen, b_seen, a_v, b_v;

  always_comb begin
    a_t = a_i ? tick : a_ts;
    b_t = b_i ? tick : b_ts;
    a_v = a_i | a_seen;
    b_v = b_i | b_seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick    <= '0;
      a_ts    <= '0;
      b_ts    <= '0;
      a_seen  <= 1'b0;
      b_seen  <= 1'b0;
      vld_o   <= 1'b0;
      phase_o <= '0;
    end else begin
      tick  <= tick + 1'b1;
      vld_o <= 1'b0;
      if (a_v && b_v) begin
        vld_o   <= 1'b1;
        phase_o <= phase_t'(b_t - a_t);
        a_seen  <= 1'b0;
        b_seen  <= 1'b0;
      end else begin
        a_seen <= a_v;
        b_seen <= b_v;
        a_ts   <= a_t;
        b_ts   <= b_t;
      end
    end
  end
endmodule

// File: rtl/pcm_iir_avg.sv
module pcm_iir_avg
  import phase_cmp_pkg::*;
#(
  parameter int K = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   vld_i,
  input  phase_t x_i,
  output phase_t avg_o
);
  localparam int AW = PHASE_W + K;

  logic signed [AW-1:0] acc, step;
  logic signed [AW:0]   xs, diff;

  always_comb begin
    xs   = {x_i[PHASE_W-1], x_i, {K{1'b0}}};
    diff = xs - {acc[AW-1], acc};
    step = AW'(diff >>> K);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else if (vld_i) acc <= acc + step;
  end

  assign avg_o = acc[AW-1:K];
endmodule

// File: rtl/phase_cmp_monitor.sv
module phase_cmp_monitor
  import phase_cmp_pkg::*;
#(
  parameter int N_REF = 8,
  parameter int DIV   = 4,
  parameter int K     = 3,
  localparam int IDX_W = (N_REF > 1) ? $clog2(N_REF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REF-1:0] ref_pulse,
  input  logic [IDX_W-1:0] pri_sel,
  input  logic [IDX_W-1:0] force_sel,
  input  logic             pri_fb_pulse,
  input  logic             sec_fb_pulse,
  input  logic             meas_mode,
  input  logic             div_mode,
  input  logic             rd_sec,
  input  logic             rd_en,
  input  logic             rd_addr,
  output logic [7:0]       rd_data,
  output logic             sec_lock_en
);
  localparam int N_DET = 2;

  logic pri_ref, frc_ref, diva_o, divb_o;
  logic [N_DET-1:0] det_a, det_b, det_hit, det_vld;
  phase_t det_ph [N_DET];
  phase_t avg_q  [N_DET];
  phase_t sel_ph;
  logic [WORD_W-1:0] rd_word;
  logic [7:0] snap_hi;

  assign pri_ref = ref_pulse[pri_sel];
  assign frc_ref = ref_pulse[force_sel];

  pcm_edge_div #(.DIV(DIV)) div_a_i (
    .clk(clk), .rst_n(rst_n), .en(div_mode),
    .pulse_i(meas_mode ? pri_ref : frc_ref), .pulse_o(diva_o)
  );
  pcm_edge_div #(.DIV(DIV)) div_b_i (
    .clk(clk), .rst_n(rst_n), .en(div_mode),
    .pulse_i(meas_mode & frc_ref), .pulse_o(divb_o)
  );

  assign det_a[0] = pri_ref;
  assign det_b[0] = pri_fb_pulse;
  assign det_a[1] = diva_o;
  assign det_b[1] = meas_mode ? divb_o : sec_fb_pulse;
  assign det_hit  = det_a | det_b;

  for (genvar g = 0; g < N_DET; g++) begin : g_path
    pcm_phase_det det_i (
      .clk(clk), .rst_n(rst_n), .a_i(det_a[g]), .b_i(det_b[g]),
      .vld_o(det_vld[g]), .phase_o(det_ph[g])
    );
    pcm_iir_avg #(.K(K)) avg_i (
      .clk(clk), .rst_n(rst_n), .vld_i(det_vld[g]), .x_i(det_ph[g]),
      .avg_o(avg_q[g])
    );
  end

  assign sel_ph  = rd_sec ? avg_q[1] : avg_q[0];
  assign rd_word = {{(WORD_W-PHASE_W){sel_ph[PHASE_W-1]}}, sel_ph};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data     <= '0;
      snap_hi     <= '0;
      sec_lock_en <= 1'b1;
    end else begin
      sec_lock_en <= !meas_mode;
      if (rd_en) begin
        if (!rd_addr) begin
          rd_data <= rd_word[7:0];
          snap_hi <= rd_word[15:8];
        end else begin
          rd_data <= snap_hi;
        end
      end
    end
  end
endmodule

// File: rtl/phase_cmp_monitor_chk.sv
module phase_cmp_monitor_chk
  import phase_cmp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       meas_mode,
  input logic       sec_lock_en,
  input logic       rd_en,
  input logic       rd_addr,
  input logic [7:0] rd_data,
  input logic [1:0] det_vld,
  input logic [1:0] det_hit,
  input phase_t     avg1
);
  AST_LOCK_OFF_IN_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    meas_mode |=> !sec_lock_en); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R11
  AST_HI_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr) |=> (rd_data == 8'h00 || rd_data == 8'hFF)); // R12
  AST_PRI_SAMPLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    det_vld[0] |-> $past(det_hit[0])); // R8
  AST_SEC_SAMPLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    det_vld[1] |-> $past(det_hit[1])); // R3
  AST_AVG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(det_vld[1]) |-> $stable(avg1)); // R9
endmodule

bind phase_cmp_monitor phase_cmp_monitor_chk chk_i (
  .clk(clk), .rst_n(rst_n), .meas_mode(meas_mode), .sec_lock_en(sec_lock_en),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .det_vld(det_vld), .det_hit(det_hit), .avg1(avg_q[1])
);

// File: tb/phase_cmp_monitor_tb.sv
`timescale 1ns/1ps
module phase_cmp_monitor_tb_top;
  localparam int N_REF = 8;
  localparam int DIV   = 4;
  localparam int K     = 3;
  localparam int IDX_W = 3;
  localparam int GLEN  = 600;
  localparam int GMID  = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_REF-1:0] ref_pulse = '0;
  logic [IDX_W-1:0] pri_sel = '0, force_sel = '0;
  logic pri_fb_pulse = 0, sec_fb_pulse = 0, meas_mode = 0, div_mode = 0;
  logic rd_sec = 0, rd_en = 0, rd_addr = 0;
  logic [7:0] rd_data;
  logic sec_lock_en;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int acc_p, acc_s, div_cnt;

  always #2 clk = ~clk;

  phase_cmp_monitor #(.N_REF(N_REF), .DIV(DIV), .K(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .pri_sel(pri_sel),
    .force_sel(force_sel), .pri_fb_pulse(pri_fb_pulse), .sec_fb_pulse(sec_fb_pulse),
    .meas_mode(meas_mode), .div_mode(div_mode), .rd_sec(rd_sec), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .sec_lock_en(sec_lock_en)
  );

  function automatic int wrap9(int v);
    int m = ((v % 512) + 512) % 512;
    return (m >= 256) ? m - 512 : m;
  endfunction

  function automatic int iir(int acc, int x);
    return acc + (((x <<< K) - acc) >>> K);
  endfunction

  function automatic logic [15:0] word_of(int acc);
    return 16'(acc >>> K);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    acc_p = 0; acc_s = 0; div_cnt = 0;
  endtask

  task automatic rd_byte(input logic a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic rd_word(input logic sel, output logic [15:0] w);
    logic [7:0] lo, hi;
    @(negedge clk); rd_sec = sel;
    rd_byte(1'b0, lo);
    rd_byte(1'b1, hi);
    w = {hi, lo};
  endtask

  // one edge group: primary ref at GMID, forced ref at GMID+ds,
  // primary feedback at GMID+dp, secondary feedback at GMID+df
  task automatic group(int dp, int ds, int df);
    for (int c = 0; c < GLEN; c++) begin
      @(negedge clk);
      ref_pulse = '0; pri_fb_pulse = 0; sec_fb_pulse = 0;
      if (c == GMID) ref_pulse[pri_sel] = 1'b1;
      if (c == GMID + ds) ref_pulse[force_sel] = 1'b1;
      if (c == GMID + dp) pri_fb_pulse = 1'b1;
      if (c == GMID + df) sec_fb_pulse = 1'b1;
    end
    @(negedge clk); ref_pulse = '0; pri_fb_pulse = 0; sec_fb_pulse = 0;
    acc_p = iir(acc_p, wrap9(dp));
    if (meas_mode) begin
      if (!div_mode) acc_s = iir(acc_s, wrap9(ds));
      else begin
        if (div_cnt == DIV - 1) acc_s = iir(acc_s, wrap9(ds));
        div_cnt = (div_cnt + 1) % DIV;
      end
    end else begin
      acc_s = iir(acc_s, wrap9(df - ds));
    end
  endtask

  function automatic int rnd(int span);
    return int'($urandom_range(2 * span)) - span;
  endfunction

  initial begin
    logic [15:0] w;
    logic [7:0] b, b2;
    void'($urandom(32'd4711));
    do_reset();

    // R1: reset state
    @(negedge clk);
    check("R1 lock_en", {15'd0, sec_lock_en}, 16'd1);
    rd_word(1'b0, w); check("R1 primary", w, 16'h0000);
    rd_word(1'b1, w); check("R1 secondary", w, 16'h0000);

    // R2 R3 R6 R7 R8: measure mode, direct, random offsets, feedback ignored
    pri_sel = 3'd2; force_sel = 3'd5; meas_mode = 1; div_mode = 0;
    @(negedge clk); @(negedge clk);
    check("R2 lock_en off", {15'd0, sec_lock_en}, 16'd0);
    for (int i = 0; i < 20; i++) group(rnd(250), rnd(250), rnd(250));
    rd_word(1'b1, w); check("R3 R6 R7 secondary measure", w, word_of(acc_s));
    rd_word(1'b0, w); check("R8 R10 primary in measure", w, word_of(acc_p));

    // R4: force the primary's own reference, samples of zero
    pri_sel = 3'd3; force_sel = 3'd3;
    for (int i = 0; i < 12; i++) group(rnd(200), 0, rnd(200));
    rd_word(1'b1, w); check("R4 same reference", w, word_of(acc_s));
    rd_word(1'b0, w); check("R8 primary after reselect", w, word_of(acc_p));

    // R5: divided measure mode
    do_reset();
    pri_sel = 3'd0; force_sel = 3'd7; meas_mode = 1; div_mode = 1;
    for (int i = 0; i < 16; i++) group(rnd(150), rnd(250), 0);
    rd_word(1'b1, w); check("R5 divided secondary", w, word_of(acc_s));
    rd_word(1'b0, w); check("R8 primary undivided", w, word_of(acc_p));
    // R5: three more pulses do not complete a divided sample
    for (int i = 0; i < DIV - 1; i++) group(rnd(100), 200, 0);
    rd_word(1'b1, w); check("R5 partial count", w, word_of(acc_s));

    // R7: normal mode, secondary compares forced ref with feedback
    do_reset();
    meas_mode = 0; div_mode = 0; pri_sel = 3'd1; force_sel = 3'd6;
    for (int i = 0; i < 15; i++) group(rnd(100), rnd(120), rnd(120));
    check("R2 lock_en on", {15'd0, sec_lock_en}, 16'd1);
    rd_word(1'b1, w); check("R7 normal secondary", w, word_of(acc_s));
    rd_word(1'b0, w); check("R8 R10 primary normal", w, word_of(acc_p));

    // R11 R12: snapshot coherence across a sign change
    do_reset();
    meas_mode = 1; div_mode = 0; pri_sel = 3'd4; force_sel = 3'd2;
    for (int i = 0; i < 15; i++) group(10, 100, 0);
    @(negedge clk); rd_sec = 1;
    rd_byte(1'b0, b);
    check("R11 low byte", {8'd0, b}, {8'd0, word_of(acc_s)[7:0]});
    w = word_of(acc_s);
    repeat (20) @(negedge clk);
    check("R11 hold", {8'd0, rd_data}, {8'd0, b});
    for (int i = 0; i < 20; i++) group(-10, -100, 0);
    rd_byte(1'b1, b2);
    check("R12 snapshot high", {8'd0, b2}, {8'd0, w[15:8]});
    rd_word(1'b1, w); check("R11 new word", w, word_of(acc_s));
    rd_word(1'b0, w); check("R9 R10 primary negative", w, word_of(acc_p));

    // R9: random single-step tracking
    for (int i = 0; i < 6; i++) begin
      group(rnd(250), rnd(250), 0);
      rd_word(1'b1, w); check("R9 step", w, word_of(acc_s));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule